// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers six interrupt request lines and turns them into a single, prioritized interrupt. A rising edge on a request line sets a bit in a request register. Each bit is qualified by its own mask bit and by a global enable, and a programmable priority network picks the winning source. The controller shows the program-memory address of the winner's vector entry. When the processor acknowledges the grant, the controller raises a one-cycle context-save request, latches the granted vector address, clears the winner's request bit and turns off global enable. Turning off global enable blocks further interrupts until software enables them again.

After reset the request register is held at zero. Only an enable command releases that hold. Setting the global-enable bit through a mask-register write sets the bit but leaves the hold in place. Once the hold is released, the enable command and the mask write have the same effect on global enable. Software can read the request register for polling and can write it. Request lines 4 and 5 are meant to carry the end-of-count events of two timers.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the request register, the mask register (including global enable) and the priority register read 0, `irq_pending` is 0 and `save_req` is 0.
- R2: From reset until the first `ei_cmd`, the request register stays at zero and `irq_pending` stays 0, whatever edges arrive on `irq_in` and whatever is written to the request register. Writing the mask register with bit 7 set does set global enable (it reads back as 1) but does not release this hold.
- R3: `ei_cmd` releases the hold and sets global enable. After that, a mask write with bit 7 = 1 and `ei_cmd` both set global enable. `di_cmd` clears it, and it wins over `ei_cmd` in the same cycle.
- R4: A rising edge on `irq_in[n]` sets request bit n at the next clock edge. A line held high sets its bit only once per assertion.
- R5: `irq_pending` is 1 exactly when some n has request bit n, mask bit n and global enable all set.
- R6: The priority register works as follows. Bit 0 puts IRQ1 ahead of IRQ0. Bit 1 puts IRQ3 ahead of IRQ2. Bit 2 puts IRQ5 ahead of IRQ4. Bits 5:3 select the order of the pairs A={0,1}, B={2,3}, C={4,5}: 0 gives A,B,C; 1 gives A,C,B; 2 gives B,A,C; 3 gives B,C,A; 4 gives C,A,B; 5 gives C,B,A; 6 and 7 act as 0. The reset value 0 gives IRQ0 highest and IRQ5 lowest.
- R7: `pend_vec` equals 2 × n for the winning source IRQn.
- R8: If `grant_ack` is high at a clock edge while `irq_pending` is high, then in the following cycle `save_req` is 1 for one cycle, `grant_vec` holds 2 × n, global enable is 0, and request bit n is cleared while the other request bits are kept.
- R9: Register select codes on `wr_sel`/`rd_sel` are: 0 = request (bits 5:0), 1 = mask (bit 7 global enable, bits 5:0 per-source, bit 6 reads 0), 2 = priority (bits 5:0), 3 = reads 0. Reads are combinational. Writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 6 | Interrupt request lines, edge captured |
| ei_cmd | input | 1 | Enable-interrupts command pulse |
| di_cmd | input | 1 | Disable-interrupts command pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Register write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 8 | Register read data |
| grant_ack | input | 1 | Processor accepts the pending interrupt |
| irq_pending | output | 1 | An eligible request exists |
| pend_vec | output | 4 | Vector address of the current winner |
| save_req | output | 1 | One-cycle request to save context |
| grant_vec | output | 4 | Vector address latched at the grant |

## Verification
`irq_pending`, `pend_vec` and `rd_data` are combinational from registered state, so they are due in the same cycle as any change to that state. A register write, a request edge, a command or an acknowledge driven after one falling edge is therefore visible at the next falling edge, one rising edge later. The bench drives every input just after a falling edge and samples one falling edge later, with a short settle after changing `rd_sel`. The grant results `save_req` and `grant_vec` appear one cycle after the acknowledging edge, and the bench checks that `save_req` has dropped again one cycle after that. The priority sweep covers all 64 priority codes against all 63 nonzero request patterns.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int NSRC    = 6;
    localparam int NGRP    = NSRC / 2;
    localparam int IDW     = $clog2(NSRC);
    localparam int VECW    = IDW + 1;
    localparam int DW      = 8;
    localparam int GIE_BIT = DW - 1;
    localparam int ORDW    = 3;

    typedef enum logic [1:0] {
        SEL_REQ  = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PRIO = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic           valid;
        logic [IDW-1:0] id;
    } pick_t;

    // group index placed at a given rank (rank 0 = highest) for an order code
    function automatic logic [1:0] group_at(input logic [ORDW-1:0] code, input int rank);
        logic [5:0] perm;
        case (code)
            3'd1:    perm = {2'd1, 2'd2, 2'd0};
            3'd2:    perm = {2'd2, 2'd0, 2'd1};
            3'd3:    perm = {2'd0, 2'd2, 2'd1};
            3'd4:    perm = {2'd1, 2'd0, 2'd2};
            3'd5:    perm = {2'd0, 2'd1, 2'd2};
            default: perm = {2'd2, 2'd1, 2'd0};
        endcase
        return perm[2*rank +: 2];
    endfunction

    function automatic logic [VECW-1:0] vec_of(input logic [IDW-1:0] id);
        return {id, 1'b0};
    endfunction

endpackage

// File: rtl/pic_capture.sv
module pic_capture
    import pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_in,
    input  logic            hold,
    input  logic            wr_en,
    input  logic [NSRC-1:0] wr_data,
    input  logic            clr_en,
    input  logic [IDW-1:0]  clr_id,
    output logic [NSRC-1:0] req_o
);

    logic [NSRC-1:0] irq_q;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] base;
    logic [NSRC-1:0] req_n;

    assign rise = irq_in & ~irq_q;

    always_comb begin
        base = wr_en ? wr_data : req_o;
        if (clr_en) base[clr_id] = 1'b0;
        req_n = base | rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            req_o <= '0;
        end else begin
            irq_q <= irq_in;
            req_o <= hold ? '0 : req_n;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_edge
        // R4
        edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
            (!hold && irq_in[i] && !irq_q[i]) |=> req_o[i]);
    end

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] elig,
    input  logic [ORDW-1:0] order_code,
    input  logic [NGRP-1:0] swap,
    output pick_t           pick
);

    logic [NGRP-1:0] any;
    logic [NGRP-1:0] which;

    for (genvar g = 0; g < NGRP; g++) begin : g_pair
        logic lo, hi;
        assign lo       = elig[2*g];
        assign hi       = elig[2*g+1];
        assign any[g]   = lo | hi;
        assign which[g] = swap[g] ? hi : ~lo;
    end

    always_comb begin
        logic [1:0] grp;
        pick = '0;
        for (int r = NGRP - 1; r >= 0; r--) begin
            grp = group_at(order_code, r);
            if (any[grp]) begin
                pick.valid = 1'b1;
                pick.id    = {grp, which[grp]};
            end
        end
    end

    // R5
    pick_legal_chk: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> elig[pick.id]);

    // R5
    none_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (elig != '0) |-> pick.valid);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_in,
    input  logic            ei_cmd,
    input  logic            di_cmd,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [DW-1:0]   wr_data,
    input  logic [1:0]      rd_sel,
    output logic [DW-1:0]   rd_data,
    input  logic            grant_ack,
    output logic            irq_pending,
    output logic [VECW-1:0] pend_vec,
    output logic            save_req,
    output logic [VECW-1:0] grant_vec
);

    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] prio_q;
    logic            gie_q;
    logic            gie_n;
    logic            hold_q;
    logic            save_q;
    logic [VECW-1:0] gvec_q;
    logic [NSRC-1:0] req_w;
    logic [NSRC-1:0] elig;
    pick_t           pick;
    logic [IDW-1:0]  pick_id;
    logic            take;
    logic            wr_req, wr_mask, wr_prio;
    logic            unused_bits;

    assign unused_bits = wr_data[GIE_BIT-1];

    assign wr_req  = wr_en && (wr_sel == SEL_REQ);
    assign wr_mask = wr_en && (wr_sel == SEL_MASK);
    assign wr_prio = wr_en && (wr_sel == SEL_PRIO);

    assign elig    = req_w & mask_q & {NSRC{gie_q}};
    assign pick_id = pick.id;
    assign take    = grant_ack && pick.valid;

    pic_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .hold    (hold_q),
        .wr_en   (wr_req),
        .wr_data (wr_data[NSRC-1:0]),
        .clr_en  (take),
        .clr_id  (pick_id),
        .req_o   (req_w)
    );

    pic_arbiter u_arbiter (
        .clk        (clk),
        .rst        (rst),
        .elig       (elig),
        .order_code (prio_q[NSRC-1:NGRP]),
        .swap       (prio_q[NGRP-1:0]),
        .pick       (pick)
    );

    always_comb begin
        gie_n = gie_q;
        if (wr_mask) gie_n = wr_data[GIE_BIT];
        if (ei_cmd)  gie_n = 1'b1;
        if (di_cmd)  gie_n = 1'b0;
        if (take)    gie_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            prio_q <= '0;
            gie_q  <= 1'b0;
            hold_q <= 1'b1;
            save_q <= 1'b0;
            gvec_q <= '0;
        end else begin
            gie_q  <= gie_n;
            save_q <= take;
            if (take)    gvec_q <= vec_of(pick.id);
            if (ei_cmd)  hold_q <= 1'b0;
            if (wr_mask) mask_q <= wr_data[NSRC-1:0];
            if (wr_prio) prio_q <= wr_data[NSRC-1:0];
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_REQ:  rd_data = {{(DW-NSRC){1'b0}}, req_w};
            SEL_MASK: rd_data = {gie_q, {(DW-NSRC-1){1'b0}}, mask_q};
            SEL_PRIO: rd_data = {{(DW-NSRC){1'b0}}, prio_q};
            default:  rd_data = '0;
        endcase
    end

    assign irq_pending = pick.valid;
    assign pend_vec    = pick.valid ? vec_of(pick.id) : '0;
    assign save_req    = save_q;
    assign grant_vec   = gvec_q;

    // R2
    hold_empty_chk: assert property (@(posedge clk) disable iff (rst)
        hold_q |-> (req_w == '0));

    // R8
    grant_drops_gie_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (!gie_q && save_q));

    // R8
    grant_vec_chk: assert property (@(posedge clk) disable iff (rst)
        save_q |-> (grant_vec == vec_of($past(pick_id))));

    // R3
    hold_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_q) |-> $past(ei_cmd));

endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] irq_in;
    logic       ei_cmd, di_cmd, wr_en, grant_ack;
    logic [1:0] wr_sel, rd_sel;
    logic [7:0] wr_data, rd_data;
    logic       irq_pending, save_req;
    logic [3:0] pend_vec, grant_vec;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .ei_cmd(ei_cmd), .di_cmd(di_cmd),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .grant_ack(grant_ack), .irq_pending(irq_pending),
        .pend_vec(pend_vec), .save_req(save_req), .grant_vec(grant_vec)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output int val);
        rd_sel = sel;
        #1;
        val = int'(rd_data);
    endtask

    // expected winner from the priority rules of R6; -1 when nothing is eligible
    function automatic int model(input int e, input int p);
        int oc, g, first, second;
        int ord[3];
        oc = (p >> 3) & 7;
        case (oc)
            1:       ord = '{0, 2, 1};
            2:       ord = '{1, 0, 2};
            3:       ord = '{1, 2, 0};
            4:       ord = '{2, 0, 1};
            5:       ord = '{2, 1, 0};
            default: ord = '{0, 1, 2};
        endcase
        for (int r = 0; r < 3; r++) begin
            g = ord[r];
            first  = ((p >> g) & 1) ? 2*g + 1 : 2*g;
            second = ((p >> g) & 1) ? 2*g : 2*g + 1;
            if ((e >> first) & 1)  return first;
            if ((e >> second) & 1) return second;
        end
        return -1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int v, w;
        rst = 1'b1; irq_in = '0; ei_cmd = 0; di_cmd = 0; wr_en = 0;
        wr_sel = '0; wr_data = '0; rd_sel = '0; grant_ack = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        rd(0, v); chk("R1 req", v, 0);
        rd(1, v); chk("R1 mask", v, 0);
        rd(2, v); chk("R1 prio", v, 0);
        chk("R1 pending", irq_pending, 0);
        chk("R1 save", save_req, 0);

        // R2 hold until first enable command
        irq_in = 6'h3F; tick(); irq_in = '0; tick();
        rd(0, v); chk("R2 req after edges", v, 0);
        wr(1, 8'hBF);
        rd(1, v); chk("R2 gie set by write", v, 8'hBF);
        irq_in = 6'h3F; tick(); irq_in = '0; tick();
        rd(0, v); chk("R2 req still held", v, 0);
        chk("R2 pending", irq_pending, 0);
        wr(0, 8'h3F);
        rd(0, v); chk("R2 req write ignored", v, 0);

        // R3 release, R4 edge capture, R7 vector
        ei_cmd = 1; tick(); ei_cmd = 0;
        rd(1, v); chk("R3 gie after ei", v, 8'hBF);
        irq_in = 6'h08; tick();
        rd(0, v); chk("R4 edge sets bit", v, 8'h08);
        chk("R5 pending", irq_pending, 1);
        chk("R7 vec irq3", pend_vec, 6);

        // R8 grant with line still held high
        grant_ack = 1; tick(); grant_ack = 0;
        chk("R8 save", save_req, 1);
        chk("R8 grant_vec", grant_vec, 6);
        rd(1, v); chk("R8 gie cleared", v, 8'h3F);
        rd(0, v); chk("R8 req cleared", v, 0);
        chk("R8 pending", irq_pending, 0);
        tick();
        chk("R8 save one cycle", save_req, 0);
        tick();
        rd(0, v); chk("R4 level sets once", v, 0);
        irq_in = '0;

        // R3 write equivalence, R8 other bits retained
        wr(1, 8'hBF);
        wr(0, 8'h25);
        chk("R7 vec irq0", pend_vec, 0);
        grant_ack = 1; tick(); grant_ack = 0;
        rd(0, v); chk("R8 others kept", v, 8'h24);
        chk("R8 grant_vec irq0", grant_vec, 0);
        ei_cmd = 1; tick(); ei_cmd = 0;
        chk("R3 ei re-enables", irq_pending, 1);
        chk("R7 vec irq2", pend_vec, 4);
        ei_cmd = 1; di_cmd = 1; tick(); ei_cmd = 0; di_cmd = 0;
        rd(1, v); chk("R3 di wins", v, 8'h3F);
        chk("R3 pending off", irq_pending, 0);

        // R5 per-source mask
        ei_cmd = 1; tick(); ei_cmd = 0;
        wr(1, 8'h90);
        chk("R5 masked", irq_pending, 0);
        wr(1, 8'hA0);
        chk("R5 unmasked", irq_pending, 1);
        chk("R7 vec irq5", pend_vec, 10);

        // R9 map details
        wr(1, 8'hFF);
        rd(1, v); chk("R9 mask bit6", v, 8'hBF);
        rd(3, v); chk("R9 sel3", v, 0);

        // R6 / R7 sweep over all priority codes and request patterns
        for (int p = 0; p < 64; p++) begin
            wr(2, 8'(p));
            rd(2, v); chk("R9 prio readback", v, p);
            for (int e = 1; e < 64; e++) begin
                wr(0, 8'(e));
                w = model(e, p);
                if (int'(irq_pending) != 1 || int'(pend_vec) != 2*w) begin
                    $display("  (R6 p=%0d e=%0d)", p, e);
                end
                chk("R6 pending", irq_pending, 1);
                chk("R6 R7 winner vec", pend_vec, 2*w);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule